// File: doc/BRIEF.md
# Dual-Bank Maskable Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor through two independent banks of control registers. The first bank drives a normal interrupt output and the second drives a fast interrupt output. Each bank keeps its own per-line trigger selection, polarity, enable mask, acknowledge and masked status, so one line can be routed to either output, to both, or to neither.

Every raw line passes through a two-flop synchroniser before any other logic sees it. A line can be set to detect a high level, a low level, a rising edge or a falling edge. Edge events are held in a sticky bit until software acknowledges them. Level requests follow the input directly. A bank raises its output while any enabled line is pending. Software can read the bank's status word repeatedly and service lines until the word reads zero.

Registers are reached through a single-cycle port. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is combinational from the word address. The register port carries no stream data, so it has no valid/ready handshake and never stalls.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset the enable, trigger and polarity words of both banks read 0, both status words read 0 and both interrupt outputs are low.
- R2: The source word (word address 0 or 8) returns the raw inputs after two clock edges of synchronisation, with no polarity inversion and no masking applied.
- R3: Word address bit 3 selects the bank (0 normal, 1 fast) and bits 2:0 select the register: 0 source, 1 enable, 2 acknowledge, 3 trigger, 4 polarity, 5 status. Enable, trigger and polarity read back what was written. Acknowledge and the unused codes 6 and 7 read 0. Writes to source or status change nothing.
- R4: With trigger bit 0 the line is level sensitive: polarity 0 means active high and polarity 1 means active low. Pending follows the input, and an acknowledge leaves an active level pending.
- R5: With trigger bit 1 the line is edge sensitive: polarity 0 means rising and polarity 1 means falling. A detected edge stays pending after the input returns.
- R6: Writing the acknowledge word clears the sticky edge of each line whose data bit is 1. Lines whose data bit is 0 keep their state.
- R7: When an edge is detected in the same cycle that its acknowledge is written, the line stays pending.
- R8: The status word equals pending AND enable. A line with enable 0 is absent from status and from the output, but its edge is still latched and appears once it is enabled.
- R9: Each bank's output is the OR of its status bits delayed by one register stage. The two banks do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in_i | input | 32 | Raw interrupt request lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 4 | Word address (byte offset divided by 4) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_waddr_i |
| nrm_irq_o | output | 1 | Normal-bank interrupt output |
| fast_irq_o | output | 1 | Fast-bank interrupt output |

## Verification
Edge detection and software acknowledge can both act on the same line in one cycle. The bench provokes this by counting clock edges from an input toggle through the synchroniser. It places the acknowledge write on exactly the edge where the sticky bit is set. The result is judged by reading status afterwards: the line must still be pending. A second case writes the acknowledge one cycle later, and that line must clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LINES     = 32;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned SYNC_LEN  = 2;

  typedef enum logic [2:0] {
    SEL_SRC  = 3'd0,
    SEL_EN   = 3'd1,
    SEL_ACK  = 3'd2,
    SEL_TRIG = 3'd3,
    SEL_POL  = 3'd4,
    SEL_STAT = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/intc_line.sv
module intc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_i,
  input  logic prev_i,
  input  logic trig_i,
  input  logic pol_i,
  input  logic ack_i,
  output logic pend_o
);
  logic rise, fall, evt, sticky;

  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;
  assign evt  = pol_i ? fall : rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky <= 1'b0;
    else if (!trig_i) sticky <= 1'b0;
    else if (evt)     sticky <= 1'b1;
    else if (ack_i)   sticky <= 1'b0;
  end

  assign pend_o = trig_i ? sticky : (cur_i ^ pol_i);
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] prev_i,
  input  logic         wr_i,
  input  reg_sel_e     sel_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] trig_o,
  output logic [N-1:0] pol_o,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] ack_vec, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      trig_o <= '0;
      pol_o  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_EN:   en_o   <= wdata_i;
        SEL_TRIG: trig_o <= wdata_i;
        SEL_POL:  pol_o  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign ack_vec = (wr_i && sel_i == SEL_ACK) ? wdata_i : '0;

  for (genvar i = 0; i < N; i++) begin : g_line
    intc_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur_i  (cur_i[i]),
      .prev_i (prev_i[i]),
      .trig_i (trig_o[i]),
      .pol_i  (pol_o[i]),
      .ack_i  (ack_vec[i]),
      .pend_o (pend[i])
    );
  end

  assign stat_o = pend & en_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |stat_o;
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned N      = LINES,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [N-1:0]      reg_wdata_i,
  output logic [N-1:0]      reg_rdata_o,
  output logic              nrm_irq_o,
  output logic              fast_irq_o
);
  localparam int unsigned BANK_BIT = ADDR_W - 1;

  logic [N-1:0] sync_q, sync_prev;
  logic [N-1:0] bk_en   [NUM_BANKS];
  logic [N-1:0] bk_trig [NUM_BANKS];
  logic [N-1:0] bk_pol  [NUM_BANKS];
  logic [N-1:0] bk_stat [NUM_BANKS];
  logic         bk_irq  [NUM_BANKS];
  logic         bsel;
  reg_sel_e     rsel;

  assign bsel = reg_waddr_i[BANK_BIT];
  assign rsel = reg_sel_e'(reg_waddr_i[BANK_BIT-1:0]);

  intc_sync #(.W(N), .STAGES(SYNC_LEN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_in_i),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_prev <= '0;
    else        sync_prev <= sync_q;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_here;
    assign wr_here = reg_wr_i && (bsel == b[0]);
    intc_bank #(.N(N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_i   (sync_q),
      .prev_i  (sync_prev),
      .wr_i    (wr_here),
      .sel_i   (rsel),
      .wdata_i (reg_wdata_i),
      .en_o    (bk_en[b]),
      .trig_o  (bk_trig[b]),
      .pol_o   (bk_pol[b]),
      .stat_o  (bk_stat[b]),
      .irq_o   (bk_irq[b])
    );
  end

  always_comb begin
    case (rsel)
      SEL_SRC:  reg_rdata_o = sync_q;
      SEL_EN:   reg_rdata_o = bk_en[bsel];
      SEL_TRIG: reg_rdata_o = bk_trig[bsel];
      SEL_POL:  reg_rdata_o = bk_pol[bsel];
      SEL_STAT: reg_rdata_o = bk_stat[bsel];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign nrm_irq_o  = bk_irq[0];
  assign fast_irq_o = bk_irq[1];
endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr_i,
  input logic [3:0]   reg_waddr_i,
  input logic [N-1:0] reg_wdata_i,
  input logic [N-1:0] reg_rdata_o,
  input logic         nrm_irq_o,
  input logic         fast_irq_o,
  input logic [N-1:0] cur,
  input logic [N-1:0] prev,
  input logic [N-1:0] en_n,
  input logic [N-1:0] en_f,
  input logic [N-1:0] trig_n,
  input logic [N-1:0] trig_f,
  input logic [N-1:0] pol_n,
  input logic [N-1:0] pol_f,
  input logic [N-1:0] stat_n,
  input logic [N-1:0] stat_f
);
  logic [N-1:0] evt_n, evt_f;
  logic         ack_n, ack_f;

  assign evt_n = trig_n & ((pol_n & prev & ~cur) | (~pol_n & cur & ~prev));
  assign evt_f = trig_f & ((pol_f & prev & ~cur) | (~pol_f & cur & ~prev));
  assign ack_n = reg_wr_i && reg_waddr_i == 4'h2;
  assign ack_f = reg_wr_i && reg_waddr_i == 4'hA;

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!nrm_irq_o && !fast_irq_o));

  p_ack_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_waddr_i[2:0] == 3'd2) |-> (reg_rdata_o == '0));

  p_ack_clears_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n |=> (($past(reg_wdata_i & trig_n & en_n & ~evt_n) & stat_n) == '0));

  p_ack_clears_f_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_f |=> (($past(reg_wdata_i & trig_f & en_f & ~evt_f) & stat_f) == '0));

  p_zero_bits_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n |=> (($past(stat_n & trig_n & ~reg_wdata_i) & ~stat_n) == '0));

  p_edge_beats_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n |=> (($past(evt_n & en_n) & ~stat_n) == '0));

  p_out_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_irq_o |-> $past(en_n != '0));

  p_rise_from_status_n_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nrm_irq_o) |-> $past(stat_n != '0));

  p_rise_from_status_f_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_irq_o) |-> $past(stat_f != '0));
endmodule

bind dual_bank_intc dual_bank_intc_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_waddr_i (reg_waddr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .nrm_irq_o   (nrm_irq_o),
  .fast_irq_o  (fast_irq_o),
  .cur         (sync_q),
  .prev        (sync_prev),
  .en_n        (bk_en[0]),
  .en_f        (bk_en[1]),
  .trig_n      (bk_trig[0]),
  .trig_f      (bk_trig[1]),
  .pol_n       (bk_pol[0]),
  .pol_f       (bk_pol[1]),
  .stat_n      (bk_stat[0]),
  .stat_f      (bk_stat[1])
);

// File: tb/dual_bank_intc_tb.sv
module dual_bank_intc_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_SRC = 4'h0, A_EN = 4'h1, A_ACK = 4'h2, A_TRIG = 4'h3,
                         A_POL = 4'h4, A_STAT = 4'h5, FB = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nrm_irq, fast_irq;
  int          checks = 0, failures = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in_i(irq_in), .reg_wr_i(reg_wr),
    .reg_waddr_i(reg_waddr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .nrm_irq_o(nrm_irq), .fast_irq_o(fast_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_waddr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic restore();
    for (int b = 0; b < 2; b++) begin
      wr(FB*b[3:0] | A_EN, '0);
      wr(FB*b[3:0] | A_TRIG, '0);
      wr(FB*b[3:0] | A_POL, '0);
    end
    irq_in = '0;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int b = 0; b < 2; b++) begin
      rd(FB*b[3:0] | A_EN, d);   chk("R1 enable", d, 0);
      rd(FB*b[3:0] | A_TRIG, d); chk("R1 trigger", d, 0);
      rd(FB*b[3:0] | A_POL, d);  chk("R1 polarity", d, 0);
      rd(FB*b[3:0] | A_STAT, d); chk("R1 status", d, 0);
    end
    chk("R1 outputs", {30'd0, nrm_irq, fast_irq}, 0);
  endtask

  task automatic t_source();
    logic [31:0] d;
    wr(A_POL, 32'hFFFF_FFFF);
    @(negedge clk);
    irq_in = 32'hA5A5_0F0F; reg_waddr = A_SRC;
    @(negedge clk); #1 chk("R2 one edge", reg_rdata, 0);
    @(negedge clk); #1 chk("R2 two edges", reg_rdata, 32'hA5A5_0F0F);
    rd(FB | A_SRC, d); chk("R2 fast source", d, 32'hA5A5_0F0F);
    restore();
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(A_EN, 32'h1234_5678);
    rd(A_EN, d);        chk("R3 enable readback", d, 32'h1234_5678);
    rd(FB | A_EN, d);   chk("R3 fast enable independent", d, 0);
    wr(FB | A_TRIG, 32'hCAFE_0001);
    rd(FB | A_TRIG, d); chk("R3 fast trigger readback", d, 32'hCAFE_0001);
    rd(A_TRIG, d);      chk("R3 normal trigger independent", d, 0);
    wr(A_POL, 32'h0000_FFFF);
    rd(A_POL, d);       chk("R3 polarity readback", d, 32'h0000_FFFF);
    rd(A_ACK, d);       chk("R3 ack reads zero", d, 0);
    rd(4'h6, d);        chk("R3 code 6 zero", d, 0);
    rd(FB | 4'h7, d);   chk("R3 code 7 zero", d, 0);
    wr(A_POL, 0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_SRC, 32'hFFFF_FFFF);
    rd(A_STAT, d);      chk("R3 status write ignored", d, 0);
    rd(A_SRC, d);       chk("R3 source write ignored", d, 0);
    rd(A_EN, d);        chk("R3 enable untouched", d, 32'h1234_5678);
    restore();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A_POL, 32'h2);
    wr(A_EN, 32'h3);
    irq_in = 32'h1; settle();
    rd(A_STAT, d); chk("R4 high and low active", d, 32'h3);
    chk("R4 output", {31'd0, nrm_irq}, 1);
    wr(A_ACK, 32'h3);
    rd(A_STAT, d); chk("R4 ack no lasting effect", d, 32'h3);
    irq_in = 32'h2; settle();
    rd(A_STAT, d); chk("R4 follows inactive", d, 0);
    chk("R4 output low", {31'd0, nrm_irq}, 0);
    restore();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A_TRIG, 32'h30);
    wr(A_POL, 32'h20);
    wr(A_EN, 32'h30);
    irq_in = 32'h30; settle();
    rd(A_STAT, d); chk("R5 rising only", d, 32'h10);
    irq_in = 32'h0; settle();
    rd(A_STAT, d); chk("R5 falling plus sticky rise", d, 32'h30);
    wr(A_ACK, 32'h10);
    rd(A_STAT, d); chk("R6 one clears zero keeps", d, 32'h20);
    wr(A_ACK, 32'h20);
    rd(A_STAT, d); chk("R6 last ack", d, 0);
    restore();
  endtask

  task automatic t_edge_ack();
    logic [31:0] d;
    wr(A_TRIG, 32'h8);
    wr(A_EN, 32'h8);
    irq_in = 32'h8; settle();
    irq_in = 32'h0; settle();
    rd(A_STAT, d); chk("R7 pre-pending", d, 32'h8);
    @(negedge clk); irq_in = 32'h8;
    @(posedge clk); @(posedge clk);
    wr(A_ACK, 32'h8);
    rd(A_STAT, d); chk("R7 edge wins over ack", d, 32'h8);
    irq_in = 32'h0; settle();
    @(negedge clk); irq_in = 32'h8;
    @(posedge clk); @(posedge clk); @(posedge clk);
    wr(A_ACK, 32'h8);
    rd(A_STAT, d); chk("R7 later ack clears", d, 0);
    restore();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_TRIG, 32'h40);
    irq_in = 32'h40; settle();
    rd(A_STAT, d); chk("R8 disabled absent", d, 0);
    chk("R8 output low", {31'd0, nrm_irq}, 0);
    wr(A_EN, 32'h40);
    rd(A_STAT, d); chk("R8 latched shows", d, 32'h40);
    restore();
  endtask

  task automatic t_banks();
    logic [31:0] d;
    irq_in = 32'h400; settle();
    wr(FB | A_EN, 32'h400);
    #1 chk("R9 not yet registered", {31'd0, fast_irq}, 0);
    @(negedge clk); #1 chk("R9 fast output one stage", {31'd0, fast_irq}, 1);
    chk("R9 normal unaffected", {31'd0, nrm_irq}, 0);
    rd(FB | A_STAT, d); chk("R9 fast status", d, 32'h400);
    rd(A_STAT, d);      chk("R9 normal status", d, 0);
    restore();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_source();
    t_map();
    t_level();
    t_edge();
    t_edge_ack();
    t_mask();
    t_banks();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule